// File: doc/BRIEF.md
# Reset-Configured Program Memory Mapper

This block sits between the instruction fetch unit and two flash banks. It turns each 16-bit fetch address into a bank choice (bank 0 or bank 1) and an offset inside that bank. A two-bit mapping mode register selects how the two banks are laid over the fetch address space. In the overlay mode, bank 1 covers the low 8 KB window. In the split mode, bank 0 sits low and bank 1 sits at the top 8 KB. In the two hidden modes, bank 1 cannot be reached by fetches at all.

Every reset reloads the mode register from two non-volatile start-up bits. A start-up bit reads 0 when programmed and 1 when left unprogrammed. The value loaded depends on which kind of reset occurred: cold (power-on or external pin), warm (watchdog or brown-out), or software. At run time, software may rewrite only the low mode bit. That write has no effect on the start-up bits. A write made while the fetch address lies inside the low window is reported on a one-cycle fault flag, because such a write switches memory under the running code. A fetch that falls in the gap between the two banks in split mode raises a not-visible flag.

Top module: `pmm_mapper`

## Requirements
- R1: On a clock edge with `rst_n` low or `rst_por` high, the mode loads from `cfg_nv` (bit 1 = high start-up bit, bit 0 = low start-up bit, 0 = programmed): `cfg_nv`=11 gives 00, 10 gives 01, 01 gives 10, 00 gives 11.
- R2: A `rst_wdt` edge with `cfg_nv[1]`=1 keeps mode bit 1 and sets bit 0 to the inverse of `cfg_nv[0]`. With `cfg_nv[1]`=0 it loads 10 (`cfg_nv[0]`=1) or 11 (`cfg_nv[0]`=0).
- R3: A `rst_sw` edge loads 10 when `cfg_nv[0]`=1 and 11 when `cfg_nv[0]`=0, whatever the value of `cfg_nv[1]`.
- R4: When several inputs act on the same edge, the order of priority is: cold (`rst_n` low or `rst_por`), then `rst_wdt`, then `rst_sw`, then the write port.
- R5: With no reset active, `wr_en` sets mode bit 0 to `wr_bit0` on the next edge and leaves bit 1 unchanged. A later warm reset again takes bit 0 from `cfg_nv[0]`.
- R6: In mode 00, a fetch at 0000H–1FFFH gives `bank_sel`=1 and `bank_off`=address. Any other fetch gives `bank_sel`=0 and `bank_off`=address. `not_visible` stays 0.
- R7: In mode 01, a fetch at 0000H–7FFFH gives bank 0 with offset equal to the address. A fetch at E000H–FFFFH gives bank 1 with offset equal to the address minus E000H. A fetch at 8000H–DFFFH gives bank 0 with offset equal to the address and `not_visible`=1.
- R8: In modes 10 and 11, every fetch gives `bank_sel`=0, `bank_off`=address and `not_visible`=0.
- R9: `fault_low_wr` is 1 in the cycle after an edge at which `rst_n`=1, `wr_en`=1 and `fetch_addr`≤1FFFH. Otherwise it is 0, so a single write produces a one-cycle pulse.
- R10: `map_mode` shows the mode register. `bank_sel`, `bank_off` and `not_visible` follow `map_mode` and `fetch_addr` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| rst_por | input | 1 | Power-on or external reset strobe |
| rst_wdt | input | 1 | Watchdog or brown-out reset strobe |
| rst_sw | input | 1 | Software reset strobe |
| cfg_nv | input | 2 | Non-volatile start-up bits, 0 = programmed |
| wr_en | input | 1 | Write strobe for mode bit 0 |
| wr_bit0 | input | 1 | New value for mode bit 0 |
| fetch_addr | input | 16 | Fetch address from the program counter |
| map_mode | output | 2 | Current mapping mode |
| bank_sel | output | 1 | 1 selects bank 1, 0 selects bank 0 |
| bank_off | output | 16 | Offset inside the selected bank |
| not_visible | output | 1 | Fetch lands in the split-mode gap |
| fault_low_wr | output | 1 | Mode write seen while fetching the low window |

## Verification
The assertions check on every cycle that the reset causes are ranked correctly and that each cause leaves mode bit 1 as required. They also check that a write touches only bit 0, that the gap flag appears only in split mode, that bank 1 is never selected in the hidden modes, and that the fault flag rises if and only if a low-window write occurred one edge before. The full reload table across all four start-up patterns, the exact offsets at the window edges, and the way a warm reset undoes a software write are shown only by the bench's scenarios. The bench compares these against its own model over directed cases and a seeded random stream.

// File: rtl/pmm_pkg.sv
package pmm_pkg;

  typedef enum logic [1:0] {
    MAP_OVERLAY = 2'b00,
    MAP_SPLIT   = 2'b01,
    MAP_HIDE_A  = 2'b10,
    MAP_HIDE_B  = 2'b11
  } map_e;

  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_COLD = 2'd1,
    RC_WARM = 2'd2,
    RC_SOFT = 2'd3
  } rcause_e;

  // Mode value loaded by a reset of the given cause.
  // cfg bit = 0 means programmed; low mode bit is always the inverse of cfg[0].
  function automatic logic [1:0] reload_value(rcause_e cause, logic [1:0] cfg,
                                              logic [1:0] cur);
    logic hi;
    logic lo;
    lo = ~cfg[0];
    case (cause)
      RC_COLD: hi = ~cfg[1];
      RC_WARM: hi = cfg[1] ? cur[1] : 1'b1;
      RC_SOFT: hi = 1'b1;
      default: begin
        hi = cur[1];
        lo = cur[0];
      end
    endcase
    return {hi, lo};
  endfunction

endpackage

// File: rtl/pmm_cause.sv
module pmm_cause
  import pmm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rst_por,
  input  logic    rst_wdt,
  input  logic    rst_sw,
  output rcause_e cause
);

  always_comb begin
    if (!rst_n || rst_por) cause = RC_COLD;
    else if (rst_wdt)      cause = RC_WARM;
    else if (rst_sw)       cause = RC_SOFT;
    else                   cause = RC_NONE;
  end

  // R4: cold beats warm, warm beats soft
  p_cold_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_por |-> cause == RC_COLD);
  p_warm_over_soft_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_wdt && !rst_por) |-> cause == RC_WARM);

endmodule

// File: rtl/pmm_mapreg.sv
module pmm_mapreg
  import pmm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rcause_e    cause,
  input  logic [1:0] cfg_nv,
  input  logic       wr_en,
  input  logic       wr_bit0,
  output map_e       map_q
);

  logic [1:0] load_val;
  logic       do_load;
  logic       do_write;

  assign do_load  = (cause != RC_NONE);
  assign do_write = !do_load && wr_en;
  assign load_val = reload_value(cause, cfg_nv, map_q);

  always_ff @(posedge clk) begin
    if (do_load)       map_q <= map_e'(load_val);
    else if (do_write) map_q <= map_e'({map_q[1], wr_bit0});
  end

  // R1: a cold strobe loads the inverted start-up bits
  p_cold_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == RC_COLD) |=> (map_q == {~$past(cfg_nv[1]), ~$past(cfg_nv[0])}));

  // R2: warm reset keeps the high bit when the high start-up bit is unprogrammed
  p_warm_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == RC_WARM && cfg_nv[1]) |=> (map_q[1] == $past(map_q[1])));

  // R3: software reset always lands in a hidden mode
  p_soft_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == RC_SOFT) |=> map_q[1]);

  // R5: a write only reaches bit 0
  p_write_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> (map_q[1] == $past(map_q[1]) && map_q[0] == $past(wr_bit0)));

  // R5: without load or write the mode holds
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_load && !wr_en) |=> $stable(map_q));

endmodule

// File: rtl/pmm_decode.sv
module pmm_decode
  import pmm_pkg::*;
#(
  parameter int unsigned            ADDR_W  = 16,
  parameter logic [ADDR_W-1:0]      LOW_TOP = 'h1FFF,
  parameter logic [ADDR_W-1:0]      B0_TOP  = 'h7FFF,
  parameter logic [ADDR_W-1:0]      B1_BASE = 'hE000
) (
  input  map_e              mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              bank1,
  output logic [ADDR_W-1:0] off,
  output logic              gap
);

  function automatic logic in_low(logic [ADDR_W-1:0] a);
    return a <= LOW_TOP;
  endfunction

  function automatic logic in_top(logic [ADDR_W-1:0] a);
    return a >= B1_BASE;
  endfunction

  function automatic logic in_gap(logic [ADDR_W-1:0] a);
    return (a > B0_TOP) && (a < B1_BASE);
  endfunction

  function automatic logic [ADDR_W-1:0] top_offset(logic [ADDR_W-1:0] a);
    return a - B1_BASE;
  endfunction

  always_comb begin
    bank1 = 1'b0;
    off   = addr;
    gap   = 1'b0;
    case (mode)
      MAP_OVERLAY: begin
        bank1 = in_low(addr);
      end
      MAP_SPLIT: begin
        if (in_top(addr)) begin
          bank1 = 1'b1;
          off   = top_offset(addr);
        end else begin
          gap = in_gap(addr);
        end
      end
      default: begin
        bank1 = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pmm_guard.sv
module pmm_guard #(
  parameter int unsigned       ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] LOW_TOP = 'h1FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              fault_q
);

  logic hit;
  assign hit = wr_en && (addr <= LOW_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= hit;
  end

  // R9: flag only follows a low-window write
  p_fault_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> ($past(wr_en) && ($past(addr) <= LOW_TOP)));
  p_fault_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr <= LOW_TOP)) |=> fault_q);

endmodule

// File: rtl/pmm_mapper.sv
module pmm_mapper
  import pmm_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] LOW_TOP = 'h1FFF,
  parameter logic [ADDR_W-1:0] B0_TOP  = 'h7FFF,
  parameter logic [ADDR_W-1:0] B1_BASE = 'hE000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_por,
  input  logic              rst_wdt,
  input  logic              rst_sw,
  input  logic [1:0]        cfg_nv,
  input  logic              wr_en,
  input  logic              wr_bit0,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [1:0]        map_mode,
  output logic              bank_sel,
  output logic [ADDR_W-1:0] bank_off,
  output logic              not_visible,
  output logic              fault_low_wr
);

  rcause_e cause;
  map_e    mode_q;

  pmm_cause u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_por (rst_por),
    .rst_wdt (rst_wdt),
    .rst_sw  (rst_sw),
    .cause   (cause)
  );

  pmm_mapreg u_mapreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause   (cause),
    .cfg_nv  (cfg_nv),
    .wr_en   (wr_en),
    .wr_bit0 (wr_bit0),
    .map_q   (mode_q)
  );

  pmm_decode #(
    .ADDR_W  (ADDR_W),
    .LOW_TOP (LOW_TOP),
    .B0_TOP  (B0_TOP),
    .B1_BASE (B1_BASE)
  ) u_decode (
    .mode  (mode_q),
    .addr  (fetch_addr),
    .bank1 (bank_sel),
    .off   (bank_off),
    .gap   (not_visible)
  );

  pmm_guard #(
    .ADDR_W  (ADDR_W),
    .LOW_TOP (LOW_TOP)
  ) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (fetch_addr),
    .fault_q (fault_low_wr)
  );

  assign map_mode = mode_q;

  // R7: gap flag only in split mode
  p_gap_split_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    not_visible |-> (map_mode == MAP_SPLIT));

  // R8: hidden modes never pick bank 1
  p_hidden_bank0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    map_mode[1] |-> (!bank_sel && bank_off == fetch_addr));

  // R6: overlay window served by bank 1
  p_overlay_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (map_mode == MAP_OVERLAY && fetch_addr <= LOW_TOP) |-> bank_sel);

endmodule

// File: tb/pmm_mapper_bench.sv
module pmm_mapper_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, rst_por, rst_wdt, rst_sw;
  logic [1:0]  cfg_nv;
  logic        wr_en, wr_bit0;
  logic [15:0] fetch_addr;
  logic [1:0]  map_mode;
  logic        bank_sel, not_visible, fault_low_wr;
  logic [15:0] bank_off;

  int   total = 0;
  int   bad   = 0;
  bit   finished = 0;
  logic [1:0] exp_mode;
  logic       exp_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmm_mapper u_pmm_mapper (
    .clk(clk), .rst_n(rst_n), .rst_por(rst_por), .rst_wdt(rst_wdt),
    .rst_sw(rst_sw), .cfg_nv(cfg_nv), .wr_en(wr_en), .wr_bit0(wr_bit0),
    .fetch_addr(fetch_addr), .map_mode(map_mode), .bank_sel(bank_sel),
    .bank_off(bank_off), .not_visible(not_visible), .fault_low_wr(fault_low_wr)
  );

  // Bench model of the reload table, written as a lookup per start-up pattern
  function automatic logic [1:0] bm_next(logic cold, logic wdt, logic sw, logic wr,
                                         logic wb, logic [1:0] cfg, logic [1:0] cur);
    if (cold) begin
      case (cfg)
        2'b11: return 2'b00;
        2'b10: return 2'b01;
        2'b01: return 2'b10;
        default: return 2'b11;
      endcase
    end
    if (wdt) begin
      case (cfg)
        2'b11: return {cur[1], 1'b0};
        2'b10: return {cur[1], 1'b1};
        2'b01: return 2'b10;
        default: return 2'b11;
      endcase
    end
    if (sw) return (cfg[0] ? 2'b10 : 2'b11);
    if (wr) return {cur[1], wb};
    return cur;
  endfunction

  // Bench model of decode: {gap, bank, offset}
  function automatic logic [17:0] bm_map(logic [1:0] m, logic [15:0] a);
    if (m == 2'b00) return {1'b0, (a < 16'h2000), a};
    if (m == 2'b01) begin
      if (a >= 16'hE000) return {1'b0, 1'b1, a - 16'hE000};
      if (a >= 16'h8000) return {1'b1, 1'b0, a};
      return {2'b00, a};
    end
    return {2'b00, a};
  endfunction

  function automatic string rtag(logic cold, logic wdt, logic sw, logic wr);
    if ((cold && (wdt || sw)) || (wdt && sw) || ((cold || wdt || sw) && wr)) return "R4";
    if (cold) return "R1";
    if (wdt)  return "R2";
    if (sw)   return "R3";
    return "R5";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_decode();
    logic [17:0] e;
    string r;
    e = bm_map(exp_mode, fetch_addr);
    r = (exp_mode == 2'b00) ? "R6" : (exp_mode == 2'b01) ? "R7" : "R8";
    check(r, {not_visible, bank_sel, bank_off}, e);
  endtask

  // One clock: inputs set now (after a falling edge), checks at next falling edge
  task automatic step(logic n, logic por, logic wdt, logic sw, logic wr, logic wb,
                      logic [1:0] cfg, logic [15:0] a);
    string t;
    rst_n = n; rst_por = por; rst_wdt = wdt; rst_sw = sw;
    wr_en = wr; wr_bit0 = wb; cfg_nv = cfg; fetch_addr = a;
    t = rtag(!n || por, wdt, sw, wr);
    exp_fault = n && wr && (a <= 16'h1FFF);
    @(posedge clk);
    exp_mode = bm_next(!n || por, wdt, sw, wr, wb, cfg, exp_mode);
    @(negedge clk);
    check(t, {30'd0, map_mode}, {30'd0, exp_mode});
    check("R9", {31'd0, fault_low_wr}, {31'd0, exp_fault});
    check_decode();
  endtask

  task automatic idle_probe(logic [1:0] cfg, logic [15:0] a);
    step(1, 0, 0, 0, 0, 0, cfg, a);
  endtask

  function automatic logic [15:0] pick_addr();
    logic [15:0] edges [8];
    edges = '{16'h0000, 16'h1FFF, 16'h2000, 16'h7FFF,
              16'h8000, 16'hDFFF, 16'hE000, 16'hFFFF};
    if ($urandom_range(0, 1) == 0) return edges[$urandom_range(0, 7)];
    return 16'($urandom);
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    exp_mode = 2'b00;
    rst_n = 0; rst_por = 0; rst_wdt = 0; rst_sw = 0;
    wr_en = 0; wr_bit0 = 0; cfg_nv = 2'b11; fetch_addr = 16'h0000;
    @(negedge clk);

    // R1: reset state with unprogrammed bits, then every start-up pattern
    step(0, 0, 0, 0, 0, 0, 2'b11, 16'h0000);
    check("R1", {30'd0, map_mode}, 32'd0);
    for (int c = 0; c < 4; c++) begin
      step(0, 0, 0, 0, 0, 0, 2'(c), 16'h1FFF);
      idle_probe(2'(c), 16'hE000);
      idle_probe(2'(c), 16'h9000);
    end

    // R6: overlay window edges
    step(1, 1, 0, 0, 0, 0, 2'b11, 16'h1FFF);
    idle_probe(2'b11, 16'h2000);
    idle_probe(2'b11, 16'hFFFF);

    // R5 + R9: write bit 0 while in low window, then outside it
    step(1, 0, 0, 0, 1, 1, 2'b11, 16'h0100);
    idle_probe(2'b11, 16'h8000);
    check("R9", {31'd0, fault_low_wr}, 32'd0);
    idle_probe(2'b11, 16'hDFFF);
    idle_probe(2'b11, 16'hE001);
    step(1, 0, 0, 0, 1, 0, 2'b11, 16'h2000);

    // R2 + R5: warm reset undoes a software write
    step(1, 0, 0, 0, 1, 1, 2'b11, 16'h4000);
    step(1, 0, 1, 0, 0, 0, 2'b11, 16'h4000);
    check("R5", {30'd0, map_mode}, 32'd0);

    // R3: soft reset then warm keeps hidden high bit
    step(1, 0, 0, 1, 0, 0, 2'b11, 16'hE000);
    step(1, 0, 1, 0, 0, 0, 2'b11, 16'hE000);
    check("R2", {30'd0, map_mode}, 32'd2);
    step(1, 0, 0, 0, 1, 1, 2'b11, 16'h0000);
    check("R8", {31'd0, bank_sel}, 32'd0);

    // R4: simultaneous causes
    step(1, 1, 1, 1, 1, 1, 2'b11, 16'h3000);
    step(1, 0, 1, 1, 1, 0, 2'b10, 16'h3000);
    step(1, 0, 0, 1, 1, 0, 2'b10, 16'h3000);

    // R10 + random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] cfg;
      cfg = ($urandom_range(0, 15) == 0) ? 2'($urandom) : cfg_nv;
      step(($urandom_range(0, 63) != 0),
           ($urandom_range(0, 19) == 0),
           ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 3) == 0),
           1'($urandom),
           cfg, pick_addr());
      // R10: decode follows a new address within the same cycle
      fetch_addr = pick_addr();
      #1;
      check_decode();
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule